// File: doc/BRIEF.md
# System Tick Timer

This block is a periodic down-counting timer with four 32-bit word registers behind a simple synchronous register port: control/status, reload, current count and a read-only calibration word. Software loads a reload value, picks a tick source and enables the counter. The tick source is either every processor clock or only the cycles in which an external reference tick-enable is high. Each time the count steps from 1 to 0, the timer sets a sticky "reached zero" flag and can raise a one-cycle interrupt request. The counter then reloads on the next tick, so a reload of N gives a period of N+1 ticks.

The register port is a plain synchronous control interface with address, write enable, write data, read enable and read data. It has no back-pressure: every access completes in the cycle it is presented. Read data is registered and shows the state as it was before the access edge. A build-time strap declares that no reference clock exists. When it is set, the source select reads as the processor clock and cannot be changed. The 10 ms calibration value and its inexact marker are also build-time constants.

Top module: `systick_timer`

## Requirements
- R1: The word index `bus_addr[ADDR_W-1:2]` selects the register: 0 control/status, 1 reload, 2 current count, 3 calibration. Indices above 3 read as zero, and writes to them have no effect.
- R2: The control/status word has enable in bit 0, interrupt enable in bit 1, source select in bit 2 (1 = processor clock, 0 = reference tick) and the reached-zero flag in bit 16. Every other bit reads as zero. Enable, interrupt enable and the flag reset to 0. Source select resets to the strap value.
- R3: While enabled, the counter takes one step per clock when source select is 1, and one step per clock with `ref_tick_en` high when source select is 0. While disabled it holds its value.
- R4: A step from a count of 1 produces a zero event. A step from a count of 0 loads the reload value. With a nonzero reload R, events therefore repeat every R+1 steps.
- R5: With reload 0, a counter at 0 stays at 0 and produces no events.
- R6: A zero event sets the flag. A read of the control/status word clears it after returning its old value. If a clear and an event fall on the same edge, the event wins.
- R7: Any write to the current count word clears the counter and the flag, whatever the data. This write takes priority over a step in the same cycle.
- R8: `tick_irq` is high for exactly the one cycle after a zero-event edge, and only if interrupt enable was set at that edge.
- R9: The calibration word reads {NOREF strap in bit 31, SKEW in bit 30, zeros in bits 29:24, TENMS in bits 23:0}. Writes to it have no effect.
- R10: With the NOREF strap set, source select reads as 1 from reset onward, and writes of 0 to bit 2 are ignored.
- R11: The reload and current count words use bits 23:0 and read zero in bits 31:24. Reload resets to 0.
- R12: `bus_rdata` updates on the edge that samples `bus_rd_en` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ref_tick_en | input | 1 | Reference tick qualifier used when source select is 0 |
| tick_irq | output | 1 | One-cycle interrupt request on a zero event |

## Verification
The hardest case to reach is a collision on one edge: a zero event arriving together with a status read, or together with a write to the current count. Either one decides whether the flag survives. Long reload values make these collisions rare. The random stimulus therefore keeps reload values between 0 and 6 so that zero events come every few cycles. It also mixes status reads, current-count writes and random reference ticks at a high rate, and a cycle-accurate bench model checks every read and every interrupt cycle. Directed cases add a fixed period check, a zero-reload check, a reference-tick count check and a NOREF-strapped second instance.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int DATA_W = 32;

  localparam int IDX_CSR = 0;
  localparam int IDX_RVR = 1;
  localparam int IDX_CVR = 2;
  localparam int IDX_CAL = 3;

  localparam int BIT_EN    = 0;
  localparam int BIT_IE    = 1;
  localparam int BIT_CS    = 2;
  localparam int BIT_FLAG  = 16;
  localparam int BIT_SKEW  = 30;
  localparam int BIT_NOREF = 31;
endpackage

// File: rtl/st_ctrl_regs.sv
module st_ctrl_regs
  import systick_pkg::*;
#(
  parameter int  CNT_W = 24,
  parameter bit  NOREF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_csr,
  input  logic              wr_rvr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctl_en,
  output logic              ctl_ie,
  output logic              ctl_cs,
  output logic [CNT_W-1:0]  reload
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      ctl_ie <= 1'b0;
      reload <= '0;
    end else begin
      if (wr_csr) begin
        ctl_en <= wdata[BIT_EN];
        ctl_ie <= wdata[BIT_IE];
      end
      if (wr_rvr) reload <= wdata[CNT_W-1:0];
    end
  end

  generate
    if (NOREF) begin : g_fixed_src
      assign ctl_cs = 1'b1;
    end else begin : g_sel_src
      logic cs_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      cs_q <= 1'b0;
        else if (wr_csr) cs_q <= wdata[BIT_CS];
      end
      assign ctl_cs = cs_q;
    end
  endgenerate
endmodule

// File: rtl/st_down_counter.sv
module st_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             ctl_cs,
  input  logic             ref_tick_en,
  input  logic [CNT_W-1:0] reload,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step = ctl_en & (ctl_cs | ref_tick_en);
  assign hit  = step & ~clr & (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (step) begin
      if (cnt == '0)       cnt <= reload;
      else                 cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/st_event.sv
module st_event (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ctl_ie,
  input  logic rd_csr,
  input  logic wr_cvr,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= hit & ctl_ie;
      if (hit)                  flag <= 1'b1;
      else if (rd_csr | wr_cvr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/st_read_port.sv
module st_read_port
  import systick_pkg::*;
#(
  parameter int           CNT_W = 24,
  parameter int           IDX_W = 3,
  parameter logic [23:0]  TENMS = 24'h0,
  parameter bit           SKEW  = 1'b0,
  parameter bit           NOREF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic              ctl_en,
  input  logic              ctl_ie,
  input  logic              ctl_cs,
  input  logic              flag,
  input  logic [CNT_W-1:0]  reload,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    case (idx)
      IDX_W'(IDX_CSR): begin
        mux[BIT_EN]   = ctl_en;
        mux[BIT_IE]   = ctl_ie;
        mux[BIT_CS]   = ctl_cs;
        mux[BIT_FLAG] = flag;
      end
      IDX_W'(IDX_RVR): mux[CNT_W-1:0] = reload;
      IDX_W'(IDX_CVR): mux[CNT_W-1:0] = cnt;
      IDX_W'(IDX_CAL): begin
        mux[23:0]      = TENMS;
        mux[BIT_SKEW]  = SKEW;
        mux[BIT_NOREF] = NOREF;
      end
      default: mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= mux;
  end
endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
#(
  parameter int          ADDR_W = 5,
  parameter int          CNT_W  = 24,
  parameter logic [23:0] TENMS  = 24'h01E848,
  parameter bit          SKEW   = 1'b1,
  parameter bit          NOREF  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd_en,
  output logic [31:0]       bus_rdata,
  input  logic              ref_tick_en,
  output logic              tick_irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_csr, wr_rvr, wr_cvr, rd_csr;
  logic             ctl_en, ctl_ie, ctl_cs;
  logic [CNT_W-1:0] reload, cnt_q;
  logic             hit, flag_q;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign wr_csr = bus_wr_en & (idx == IDX_W'(IDX_CSR));
  assign wr_rvr = bus_wr_en & (idx == IDX_W'(IDX_RVR));
  assign wr_cvr = bus_wr_en & (idx == IDX_W'(IDX_CVR));
  assign rd_csr = bus_rd_en & (idx == IDX_W'(IDX_CSR));

  st_ctrl_regs #(.CNT_W(CNT_W), .NOREF(NOREF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_csr(wr_csr), .wr_rvr(wr_rvr),
    .wdata(bus_wdata), .ctl_en(ctl_en), .ctl_ie(ctl_ie), .ctl_cs(ctl_cs),
    .reload(reload)
  );

  st_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_cs(ctl_cs),
    .ref_tick_en(ref_tick_en), .reload(reload), .clr(wr_cvr),
    .cnt(cnt_q), .hit(hit)
  );

  st_event u_evt (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ctl_ie(ctl_ie),
    .rd_csr(rd_csr), .wr_cvr(wr_cvr), .flag(flag_q), .irq(tick_irq)
  );

  st_read_port #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .TENMS(TENMS), .SKEW(SKEW), .NOREF(NOREF)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd_en), .idx(idx),
    .ctl_en(ctl_en), .ctl_ie(ctl_ie), .ctl_cs(ctl_cs), .flag(flag_q),
    .reload(reload), .cnt(cnt_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/systick_chk.sv
module systick_chk #(
  parameter int CNT_W = 24,
  parameter bit NOREF = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_cvr,
  input logic             tick_irq,
  input logic             flag_q,
  input logic             ctl_en,
  input logic             ctl_ie,
  input logic             ctl_cs,
  input logic [CNT_W-1:0] cnt_q
);
  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> flag_q);

  // R8
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq);

  // R8
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> $past(ctl_ie));

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !wr_cvr) |=> $stable(cnt_q));

  // R7
  cvr_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cvr |=> (cnt_q == '0) && !flag_q);

  // R10
  noref_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    NOREF |-> ctl_cs);
endmodule

bind systick_timer systick_chk #(.CNT_W(CNT_W), .NOREF(NOREF)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_cvr(wr_cvr), .tick_irq(tick_irq),
  .flag_q(flag_q), .ctl_en(ctl_en), .ctl_ie(ctl_ie), .ctl_cs(ctl_cs),
  .cnt_q(cnt_q)
);

// File: tb/sim_systick_timer.sv
`timescale 1ns/1ps
module sim_systick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd_en = 1'b0;
  logic        ref_tick_en = 1'b0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  systick_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(rdata0),
    .ref_tick_en(ref_tick_en), .tick_irq(irq0)
  );

  systick_timer #(.TENMS(24'h0), .SKEW(1'b0), .NOREF(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(rdata1),
    .ref_tick_en(ref_tick_en), .tick_irq(irq1)
  );

  // bench model of u0, built from the requirements
  logic        m_en, m_ie, m_cs, m_flag, m_irq;
  logic [23:0] m_rld, m_cnt;
  logic [31:0] m_rdata;

  function automatic logic [31:0] model_read(input logic [4:0] a);
    logic [31:0] v = '0;
    case (a[4:2])
      3'd0: begin v[0] = m_en; v[1] = m_ie; v[2] = m_cs; v[16] = m_flag; end
      3'd1: v[23:0] = m_rld;
      3'd2: v[23:0] = m_cnt;
      3'd3: v = 32'h4001E848;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_reset();
    m_en = 0; m_ie = 0; m_cs = 0; m_flag = 0; m_irq = 0;
    m_rld = '0; m_cnt = '0; m_rdata = '0;
  endtask

  task automatic model_edge(input logic wr, input logic rd, input logic [4:0] a,
                            input logic [31:0] d, input logic rt);
    logic        step = m_en && (m_cs || rt);
    logic        ev = 1'b0;
    logic [23:0] ncnt = m_cnt;
    logic        nflag = m_flag;
    if (rd) m_rdata = model_read(a);
    if (wr && a[4:2] == 3'd2) ncnt = '0;
    else if (step) begin
      if (m_cnt == 0) ncnt = m_rld;
      else begin ncnt = m_cnt - 24'd1; ev = (m_cnt == 24'd1); end
    end
    if (rd && a[4:2] == 3'd0) nflag = 1'b0;
    if (wr && a[4:2] == 3'd2) nflag = 1'b0;
    if (ev) nflag = 1'b1;
    m_irq = ev && m_ie;
    if (wr && a[4:2] == 3'd0) begin m_en = d[0]; m_ie = d[1]; m_cs = d[2]; end
    if (wr && a[4:2] == 3'd1) m_rld = d[23:0];
    m_cnt = ncnt;
    m_flag = nflag;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int irq_seen = 0;

  // one bus cycle: drive after a falling edge, model at the rising edge, compare at the next falling edge
  task automatic cyc(input logic wr, input logic rd, input logic [4:0] a,
                     input logic [31:0] d, input logic rt, input string req);
    bus_wr_en = wr; bus_rd_en = rd; bus_addr = a; bus_wdata = d; ref_tick_en = rt;
    @(posedge clk);
    model_edge(wr, rd, a, d, rt);
    @(negedge clk);
    if (irq0) irq_seen++;
    chk(irq0 === m_irq, "R8 irq", {31'b0, irq0}, {31'b0, m_irq});
    if (rd) chk(rdata0 === m_rdata, req, rdata0, m_rdata);
  endtask

  task automatic idle(input int n, input logic rt);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 5'h0, 32'h0, rt, "idle");
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 R11 R9 reset values and calibration word
    cyc(0, 1, 5'h00, 0, 0, "R2 reset csr");
    chk(rdata1 === 32'h4, "R10 noref csr reset", rdata1, 32'h4);
    cyc(0, 1, 5'h04, 0, 0, "R11 reset reload");
    cyc(0, 1, 5'h0C, 0, 0, "R9 calib");
    chk(rdata1 === 32'h8000_0000, "R9 noref calib", rdata1, 32'h8000_0000);
    cyc(1, 0, 5'h0C, 32'hFFFF_FFFF, 0, "R9 write ignored");
    cyc(0, 1, 5'h0C, 0, 0, "R9 calib after write");
    cyc(1, 0, 5'h10, 32'hFFFF_FFFF, 0, "R1 unmapped write");
    cyc(0, 1, 5'h10, 0, 0, "R1 unmapped read zero");
    cyc(1, 0, 5'h04, 32'hFF00_0005, 0, "R11 reload write");
    cyc(0, 1, 5'h04, 0, 0, "R11 reload upper zero");

    // R10 strapped instance keeps source select at 1
    cyc(1, 0, 5'h00, 32'h0000_0000, 0, "csr write");
    cyc(0, 1, 5'h00, 0, 0, "R2 csr readback");
    chk(rdata1 === 32'h4, "R10 noref select forced", rdata1, 32'h4);

    // R3 reference tick stepping, source select 0
    cyc(1, 0, 5'h04, 32'd10, 0, "reload");
    cyc(1, 0, 5'h00, 32'h1, 0, "enable ref");
    idle(5, 1'b0);
    cyc(0, 1, 5'h08, 0, 0, "R3 held without ref tick");
    chk(rdata0 === 32'd0, "R3 held at zero", rdata0, 32'd0);
    idle(3, 1'b1);
    cyc(0, 1, 5'h08, 0, 0, "R3 ref tick count");
    chk(rdata0 === 32'd8, "R3 three ref ticks", rdata0, 32'd8);

    // R4 period = reload + 1 on processor clock
    cyc(1, 0, 5'h04, 32'd3, 0, "reload 3");
    cyc(1, 0, 5'h08, 32'hABCD, 0, "R7 clear");
    cyc(0, 1, 5'h08, 0, 0, "R7 cleared count");
    chk(rdata0 === 32'd0, "R7 count zero", rdata0, 32'd0);
    cyc(1, 0, 5'h00, 32'h7, 0, "enable clk + irq");
    irq_seen = 0;
    idle(40, 1'b0);
    chk(irq_seen == 10, "R4 period 4 events in 40", irq_seen, 10);
    cyc(0, 1, 5'h00, 0, 0, "R6 flag set read");
    chk(rdata0[16] === 1'b1, "R6 flag set", {31'b0, rdata0[16]}, 32'd1);

    // R5 zero reload stops events
    cyc(1, 0, 5'h04, 32'd0, 0, "reload 0");
    cyc(1, 0, 5'h08, 32'd0, 0, "clear");
    irq_seen = 0;
    idle(20, 1'b0);
    chk(irq_seen == 0, "R5 no events", irq_seen, 0);
    cyc(0, 1, 5'h08, 0, 0, "R5 stays zero");

    // random mix covering R1 R2 R6 R7 R8 R12
    for (int i = 0; i < 6000; i++) begin
      int op = $urandom_range(0, 11);
      logic [4:0] a = 5'($urandom_range(0, 4) * 4);
      logic [31:0] d = $urandom();
      logic rt = 1'($urandom_range(0, 1));
      if (a == 5'h04) d = {d[31:24], 21'b0, 3'($urandom_range(0, 6))};
      if (op < 3)       cyc(1, 0, a, d, rt, "R7 random write");
      else if (op < 5)  cyc(0, 1, 5'h00, 0, rt, "R6 random csr read");
      else if (op < 8)  cyc(0, 1, a, 0, rt, "R12 random read");
      else if (op == 8) cyc(1, 1, a, d, rt, "R1 random read+write");
      else              cyc(0, 0, a, d, rt, "idle");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule